// File: doc/BRIEF.md
# Accumulator Instruction-Cycle Sequencer

This block is the control unit and datapath of a small accumulator machine, built as a multi-cycle state machine. It holds a program counter, a memory address register, a memory buffer register, an instruction register, an accumulator, a stack pointer and an interrupt-enable flag. It drives one single-port memory through a request/ready handshake that has a write strobe. Each instruction is fetched through the address and buffer registers. The operand is then resolved in one of three ways: taken from the instruction itself, read once from memory, or read through a pointer with two chained reads. After resolution the instruction loads the operand, adds it to the accumulator, or stores the accumulator.

After each instruction the sequencer checks for a pending interrupt. It takes the interrupt only when the enable flag is set. On entry it clears the flag and pushes the program counter and then the accumulator onto a memory stack. Each push follows the same steps: copy into the buffer register, point the address register at the stack, write, and advance the stack pointer. It then jumps to a fixed handler address. A halt instruction stops all activity until reset.

An instruction word is 16 bits. Bits [15:12] hold the opcode: 1 = load, 2 = add, 3 = store, 15 = halt. Bits [11:10] hold the addressing mode: 00 = immediate, 01 = direct, 10 = through a pointer, 11 = immediate. Bits [9:0] hold a 10-bit address or immediate value.

Top module: `acc_seq_core`

## Requirements
- R1: After reset the program counter and accumulator are 0, halted is 0, no memory request is made, and interrupts are enabled. The first fetch reads address 0.
- R2: Each instruction is read from the address held in the program counter. The program counter advances by 1 for every fetch, including the fetch of a halt.
- R3: In mode 00 or mode 11 the operand is bits [9:0] of the instruction, zero-extended. No memory access is made for the operand.
- R4: In mode 01 exactly one operand read is made, at address bits [9:0], and its data is the operand.
- R5: In mode 10 a read at bits [9:0] returns a pointer. A second read at the low 10 bits of that pointer returns the operand. A store in this mode makes the first read only and then writes to the pointer address.
- R6: Load (opcode 1) replaces the accumulator with the operand. Add (opcode 2) adds the operand to the accumulator modulo 2^16.
- R7: Store (opcode 3) writes the accumulator to the resolved address. In modes 00 and 11 that address is bits [9:0].
- R8: While a request is not answered by ready, the request, write strobe, address and write data stay unchanged.
- R9: When an instruction other than halt finishes with the interrupt input high and interrupts enabled, the sequencer writes the program counter (zero-extended) to the stack-pointer address and the accumulator to the next address. It then fetches next from the handler address.
- R10: Interrupt entry clears the enable flag. Interrupts stay blocked until reset, so a held interrupt input causes no second entry.
- R11: Halt (opcode 15) sets halted. From then on no memory request is made and the program counter and accumulator do not change until reset.
- R12: Any other opcode changes no register except the program counter and makes no operand access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Level interrupt request |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Write strobe, valid with request |
| mem_addr_o | output | 10 | Memory address (address register) |
| mem_wdata_o | output | 16 | Write data (buffer register) |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_ready_i | input | 1 | Memory completes the request in this cycle |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 10 | Program counter |
| halted_o | output | 1 | Halt state reached |

## Verification
The bench uses the default 16-bit word, so the add wrap at 2^16 and the full 10-bit immediate can be reached. It overrides the stack base to 0x3F0 and the handler address to 0x300. These values keep both the interrupt frame and the handler apart from the data and pointer words of the scenarios. The memory model answers with a latency of zero, one or two cycles, depending on the scenario. Stalls therefore fall on fetches, pointer reads, operand reads and stack writes.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OPC_W  = 4;
    localparam int MODE_W = 2;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
    localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

    typedef enum logic [MODE_W-1:0] {
        MODE_IMM  = 2'b00,
        MODE_DIR  = 2'b01,
        MODE_PTR  = 2'b10,
        MODE_IMM2 = 2'b11
    } amode_t;

    typedef enum logic [3:0] {
        ST_FADDR,
        ST_FREAD,
        ST_DECODE,
        ST_PTRRD,
        ST_PTRMAR,
        ST_OPRD,
        ST_EXEC,
        ST_STWR,
        ST_CHKINT,
        ST_ICOPY,
        ST_ISP,
        ST_IWR,
        ST_IVEC,
        ST_HALT
    } seq_state_t;

endpackage

// File: rtl/acc_ifield.sv
module acc_ifield
    import acc_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int FLD_W = DATA_W - OPC_W - MODE_W
) (
    input  logic [DATA_W-1:0] word_i,
    output amode_t            mode_o,
    output logic [FLD_W-1:0]  field_o,
    output logic              is_load_o,
    output logic              is_add_o,
    output logic              is_store_o,
    output logic              is_halt_o
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc        = word_i[DATA_W-1 -: OPC_W];
        mode_o     = amode_t'(word_i[FLD_W +: MODE_W]);
        field_o    = word_i[FLD_W-1:0];
        is_load_o  = (opc == OPC_LOAD);
        is_add_o   = (opc == OPC_ADD);
        is_store_o = (opc == OPC_STORE);
        is_halt_o  = (opc == OPC_HALT);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 16
) (
    input  logic         add_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        res_o = add_i ? (acc_i + opnd_i) : opnd_i;
    end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] SP_INIT  = 10'h3F0,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 10'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              halted_o
);
    localparam int FLD_W = DATA_W - OPC_W - MODE_W;
    localparam int NSAVE = 2;
    localparam int IDX_W = (NSAVE > 1) ? $clog2(NSAVE) : 1;

    typedef struct packed {
        seq_state_t        st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [ADDR_W-1:0] sp;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic              ie;
        logic [IDX_W-1:0]  sidx;
    } regs_t;

    regs_t r_q, r_d;

    logic [DATA_W-1:0] dec_word;
    amode_t            dec_mode;
    logic [FLD_W-1:0]  dec_field;
    logic              dec_load, dec_add, dec_store, dec_halt;
    logic [DATA_W-1:0] alu_res;
    logic              done;

    assign dec_word = (r_q.st == ST_DECODE) ? r_q.mbr : r_q.ir;

    acc_ifield #(.DATA_W(DATA_W)) u_ifield (
        .word_i     (dec_word),
        .mode_o     (dec_mode),
        .field_o    (dec_field),
        .is_load_o  (dec_load),
        .is_add_o   (dec_add),
        .is_store_o (dec_store),
        .is_halt_o  (dec_halt)
    );

    acc_alu #(.W(DATA_W)) u_alu (
        .add_i  (dec_add),
        .acc_i  (r_q.acc),
        .opnd_i (r_q.mbr),
        .res_o  (alu_res)
    );

    function automatic logic [DATA_W-1:0] save_word(input logic [IDX_W-1:0] idx,
                                                    input logic [ADDR_W-1:0] pc,
                                                    input logic [DATA_W-1:0] acc);
        if (idx == '0) return DATA_W'(pc);
        return acc;
    endfunction

    always_comb begin
        mem_req_o   = (r_q.st == ST_FREAD) || (r_q.st == ST_PTRRD) || (r_q.st == ST_OPRD)
                   || (r_q.st == ST_STWR)  || (r_q.st == ST_IWR);
        mem_we_o    = (r_q.st == ST_STWR) || (r_q.st == ST_IWR);
        mem_addr_o  = r_q.mar;
        mem_wdata_o = r_q.mbr;
        acc_o       = r_q.acc;
        pc_o        = r_q.pc;
        halted_o    = (r_q.st == ST_HALT);
        done        = mem_req_o && mem_ready_i;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_FADDR: begin
                r_d.mar = r_q.pc;
                r_d.st  = ST_FREAD;
            end
            ST_FREAD: if (done) begin
                r_d.mbr = mem_rdata_i;
                r_d.pc  = r_q.pc + 1'b1;
                r_d.st  = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.ir = r_q.mbr;
                if (dec_halt) begin
                    r_d.st = ST_HALT;
                end else if (!(dec_load || dec_add || dec_store)) begin
                    r_d.st = ST_CHKINT;
                end else begin
                    r_d.mar = dec_field;
                    unique case (dec_mode)
                        MODE_PTR: r_d.st = ST_PTRRD;
                        MODE_DIR: begin
                            if (dec_store) begin
                                r_d.mbr = r_q.acc;
                                r_d.st  = ST_STWR;
                            end else begin
                                r_d.st  = ST_OPRD;
                            end
                        end
                        default: begin
                            if (dec_store) begin
                                r_d.mbr = r_q.acc;
                                r_d.st  = ST_STWR;
                            end else begin
                                r_d.mbr = DATA_W'(dec_field);
                                r_d.st  = ST_EXEC;
                            end
                        end
                    endcase
                end
            end
            ST_PTRRD: if (done) begin
                r_d.mbr = mem_rdata_i;
                r_d.st  = ST_PTRMAR;
            end
            ST_PTRMAR: begin
                r_d.mar = r_q.mbr[ADDR_W-1:0];
                if (dec_store) begin
                    r_d.mbr = r_q.acc;
                    r_d.st  = ST_STWR;
                end else begin
                    r_d.st  = ST_OPRD;
                end
            end
            ST_OPRD: if (done) begin
                r_d.mbr = mem_rdata_i;
                r_d.st  = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.acc = alu_res;
                r_d.st  = ST_CHKINT;
            end
            ST_STWR: if (done) begin
                r_d.st = ST_CHKINT;
            end
            ST_CHKINT: begin
                if (irq_i && r_q.ie) begin
                    r_d.ie   = 1'b0;
                    r_d.sidx = '0;
                    r_d.st   = ST_ICOPY;
                end else begin
                    r_d.st   = ST_FADDR;
                end
            end
            ST_ICOPY: begin
                r_d.mbr = save_word(r_q.sidx, r_q.pc, r_q.acc);
                r_d.st  = ST_ISP;
            end
            ST_ISP: begin
                r_d.mar = r_q.sp;
                r_d.st  = ST_IWR;
            end
            ST_IWR: if (done) begin
                r_d.sp = r_q.sp + 1'b1;
                if (r_q.sidx == IDX_W'(NSAVE - 1)) begin
                    r_d.st = ST_IVEC;
                end else begin
                    r_d.sidx = r_q.sidx + 1'b1;
                    r_d.st   = ST_ICOPY;
                end
            end
            ST_IVEC: begin
                r_d.pc = VEC_ADDR;
                r_d.st = ST_FADDR;
            end
            ST_HALT: r_d.st = ST_HALT;
            default: r_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_FADDR;
            r_q.sp   <= SP_INIT;
            r_q.ie   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_we_o)
            && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FREAD && mem_ready_i) |=> (pc_o == $past(pc_o) + 1'b1));

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !mem_req_o);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (halted_o && $stable(pc_o) && $stable(acc_o)));

    assert_ie_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ICOPY) |-> !r_q.ie);

    assert_imm_noacc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DECODE && !dec_store && (dec_load || dec_add)
            && (dec_mode == MODE_IMM || dec_mode == MODE_IMM2)) |=> !mem_req_o);

    assert_int_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IWR) |-> (mem_we_o && mem_addr_o == r_q.sp));
endmodule

// File: tb/acc_seq_core_tb_top.sv
module acc_seq_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] SP_BASE = 10'h3F0;
    localparam logic [9:0] HVEC    = 10'h300;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  mode;
        logic [9:0]  field;
        logic [9:0]  init;
        logic [15:0] exp_acc;
        logic [9:0]  mem_a;
        logic [15:0] exp_mem;
        logic [7:0]  exp_rd;
        logic [7:0]  exp_wr;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'h1, 2'b00, 10'h155, 10'h000, 16'h0155, 10'h000, 16'h0000, 8'd3, 8'd0},
        '{4'h1, 2'b01, 10'h080, 10'h000, 16'h0042, 10'h000, 16'h0000, 8'd4, 8'd0},
        '{4'h1, 2'b10, 10'h100, 10'h000, 16'h1234, 10'h000, 16'h0000, 8'd5, 8'd0},
        '{4'h2, 2'b00, 10'h3FF, 10'h001, 16'h0400, 10'h000, 16'h0000, 8'd3, 8'd0},
        '{4'h2, 2'b01, 10'h080, 10'h010, 16'h0052, 10'h000, 16'h0000, 8'd4, 8'd0},
        '{4'h2, 2'b10, 10'h100, 10'h001, 16'h1235, 10'h000, 16'h0000, 8'd5, 8'd0},
        '{4'h2, 2'b01, 10'h081, 10'h002, 16'h0001, 10'h000, 16'h0000, 8'd4, 8'd0},
        '{4'h3, 2'b01, 10'h090, 10'h077, 16'h0077, 10'h090, 16'h0077, 8'd3, 8'd1},
        '{4'h3, 2'b10, 10'h101, 10'h123, 16'h0123, 10'h210, 16'h0123, 8'd4, 8'd1},
        '{4'h3, 2'b00, 10'h095, 10'h055, 16'h0055, 10'h095, 16'h0055, 8'd3, 8'd1},
        '{4'h0, 2'b01, 10'h080, 10'h033, 16'h0033, 10'h000, 16'h0000, 8'd3, 8'd0},
        '{4'h1, 2'b11, 10'h2A5, 10'h000, 16'h02A5, 10'h000, 16'h0000, 8'd3, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [9:0]  mem_addr, pc;
    logic [15:0] mem_wdata, mem_rdata, acc;
    logic        halted;

    logic [15:0] mem [0:1023];
    int lat = 0;
    int cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int halt_req = 0;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_seq_core #(.SP_INIT(SP_BASE), .VEC_ADDR(HVEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
        .acc_o(acc), .pc_o(pc), .halted_o(halted)
    );

    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (halted) halt_req++;
            if (cnt >= lat) begin
                mem_ready = 1'b1;
                mem_rdata = mem[mem_addr];
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    rd_cnt++;
                end
            end else begin
                cnt++;
            end
        end
    end

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        mem[10'h080] = 16'h0042;
        mem[10'h081] = 16'hFFFF;
        mem[10'h100] = 16'h0200;
        mem[10'h101] = 16'h0210;
        mem[10'h200] = 16'h1234;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        halt_req = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string req);
        int n;
        n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(req, 16'(halted), 16'h0001);
    endtask

    initial begin
        clear_mem();
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pc", 16'(pc), 16'h0000);
        chk("R1 acc", acc, 16'h0000);
        chk("R1 halted", 16'(halted), 16'h0000);
        chk("R1 req", 16'(mem_req), 16'h0000);

        // table walk: R2..R7, R12, R3 mode 11, with varying latency (R8)
        for (int v = 0; v < NVEC; v++) begin
            clear_mem();
            lat = v % 3;
            mem[0] = {4'h1, 2'b00, VECS[v].init};
            mem[1] = {VECS[v].op, VECS[v].mode, VECS[v].field};
            mem[2] = 16'hF000;
            do_reset();
            wait_halt("R11 halt reached");
            chk("R6 R3 R4 R5 R12 acc", acc, VECS[v].exp_acc);
            chk("R2 pc after halt", 16'(pc), 16'h0003);
            chk("R3 R4 R5 R12 reads", 16'(rd_cnt), 16'(VECS[v].exp_rd));
            chk("R7 writes", 16'(wr_cnt), 16'(VECS[v].exp_wr));
            if (VECS[v].exp_wr != 0)
                chk("R7 stored word", mem[VECS[v].mem_a], VECS[v].exp_mem);
        end

        // R11: nothing moves after halt
        repeat (40) @(negedge clk);
        chk("R11 no request", 16'(halt_req), 16'h0000);
        chk("R11 pc held", 16'(pc), 16'h0003);
        chk("R11 acc held", acc, 16'h02A5);

        // R9 / R10: interrupt entry with irq held high
        clear_mem();
        lat = 1;
        mem[0] = {4'h1, 2'b00, 10'h0AB};
        mem[1] = 16'hF000;
        mem[HVEC] = {4'h2, 2'b00, 10'h002};
        mem[HVEC + 10'd1] = 16'hF000;
        mem[SP_BASE + 10'd2] = 16'hDEAD;
        irq = 1'b1;
        do_reset();
        wait_halt("R9 handler halt");
        chk("R9 saved pc", mem[SP_BASE], 16'h0001);
        chk("R9 saved acc", mem[SP_BASE + 10'd1], 16'h00AB);
        chk("R9 pc in handler", 16'(pc), 16'(HVEC + 10'd2));
        chk("R9 handler acc", acc, 16'h00AD);
        chk("R10 no second frame", mem[SP_BASE + 10'd2], 16'hDEAD);
        chk("R10 write count", 16'(wr_cnt), 16'h0002);
        irq = 1'b0;

        summary();
        $finish;
    end
endmodule